// File: doc/BRIEF.md
# SDRAM Clock-Enable and Rank Output Controller

This block drives the clock-enable (CKE) lines of a four-rank SDRAM interface. It also drives the output enables that let the pads float the CKE and chip-select pins of ranks that are not fitted. From reset, every CKE is held low and every output enable is on. This makes the memory devices float their data and strobe pins. CKE stays low until two conditions are both met: a minimum low time has been counted out in memory-clock cycles, and software has set a release bit in the block's configuration register. Once the block is running, each fitted rank passes on the CKE level that the higher-level memory controller asks for.

Software writes the configuration register through a one-cycle write strobe. The register carries a release bit and a four-bit fitted-rank mask, and the mask comes out of reset with every rank marked fitted. When a rank is marked absent, its CKE and chip-select output enables drop. If that rank's CKE is high at the moment it is removed, the block first drives CKE low for one cycle and only then lets go of the pin. A ready flag reports that the block has left the low-hold phase.

Two state machines do the work. The init machine has three states. COUNT waits for the low-time timer. SW_WAIT waits for the release bit. RUN is final until reset. Its transitions are COUNT→RUN (timer expired and release already set), COUNT→SW_WAIT (timer expired, release clear) and SW_WAIT→RUN (release set). Each rank has a lane machine with four states: HOLD drives low, FOLLOW tracks the request, PARK drives low for one cycle before letting go, and OFF floats the pins. Its transitions are:
- HOLD→FOLLOW on run, HOLD→OFF on removal.
- FOLLOW→PARK on removal while CKE is high, and FOLLOW→OFF on removal while CKE is low.
- PARK→OFF always.
- OFF→HOLD or OFF→FOLLOW on re-fitting, the choice depending on run.

Top module: `cke_rank_ctrl`

## Requirements
- R1: While the reset is asserted, and in the first cycle after it, every cke_o bit is 0, every cke_oe_o and cs_oe_o bit is 1, and ready_o is 0.
- R2: Until the init machine reaches RUN, cke_o stays 0 on every rank whatever cke_req_i and the release bit hold.
- R3: The minimum low time is LIMIT = CLK_MHZ*MIN_LOW_US cycles, counted from the first clock edge after reset. If release is already set, ready_o rises after edge LIMIT+1 and fitted ranks follow their request after edge LIMIT+2. Before that, cke_o is 0.
- R4: If release is written only after the count has expired, ready_o rises one edge after the write edge, and CKE follows the request one edge after that.
- R5: In RUN, cke_o[i] of a fitted rank equals cke_req_i[i] as sampled at the previous clock edge.
- R6: Configuration write: when cfg_wr_i is 1 at an edge, cfg_release_i and cfg_mask_i are stored. Bit i of the mask is 1 when rank i is fitted. The mask resets to 4'b1111 and the release bit resets to 0.
- R7: A rank whose stored mask bit is 0 has cke_oe_o[i]=0, cs_oe_o[i]=0 and cke_o[i]=0. Its enables drop on the second edge after the write, both before and after RUN.
- R8: If a rank is removed while its cke_o is 1, then on the second edge after the write its cke_o goes 0 with its enables still 1, and on the third edge its enables go 0.
- R9: Setting a mask bit again restores that rank's enables on the second edge after the write. In RUN, the rank's cke_o follows the request from that same edge; before RUN, cke_o stays 0.
- R10: Once ready_o is 1 it stays 1 until reset. Clearing the release bit afterwards has no effect on ready_o or cke_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_release_i | input | 1 | Release bit value to store |
| cfg_mask_i | input | 4 | Fitted-rank mask to store, bit i = rank i |
| cke_req_i | input | 4 | Per-rank CKE level requested by the memory controller |
| cke_o | output | 4 | Per-rank CKE level |
| cke_oe_o | output | 4 | Per-rank CKE pad output enable |
| cs_oe_o | output | 4 | Per-rank chip-select pad output enable |
| ready_o | output | 1 | Low-hold phase finished |

## Verification
Two events can land on the same cycle: a rank being removed through the mask, and that rank driving CKE high on the controller's request. The bench writes a mask that clears a rank whose request is still high, then checks that the lane parks for exactly one cycle with CKE low and enables on before it floats. It does the same for a rank whose CKE is already low, which must float at once. A second pairing writes a cleared release bit in the same cycle as a mask that re-fits two ranks. The bench checks that the re-fitted ranks resume following their request while ready_o and the other lanes are left unchanged.

// File: rtl/cke_pkg.sv
package cke_pkg;

    typedef enum logic [1:0] {
        INIT_COUNT,
        INIT_SW_WAIT,
        INIT_RUN
    } init_state_e;

    typedef enum logic [1:0] {
        LANE_HOLD,
        LANE_FOLLOW,
        LANE_PARK,
        LANE_OFF
    } lane_state_e;

endpackage

// File: rtl/cke_cfg_reg.sv
module cke_cfg_reg #(
    parameter int RANKS = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic             release_i,
    input  logic [RANKS-1:0] mask_i,
    output logic             release_o,
    output logic [RANKS-1:0] mask_o
);

    logic             release_q;
    logic [RANKS-1:0] mask_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            release_q <= 1'b0;
            mask_q    <= '1;
        end else if (wr_i) begin
            release_q <= release_i;
            mask_q    <= mask_i;
        end
    end

    assign release_o = release_q;
    assign mask_o    = mask_q;

    // R6: every rank is treated as fitted straight after reset
    p_mask_reset_r6: assert property (@(posedge clk_i)
        rst_i |=> (mask_q == '1 && !release_q));

endmodule

// File: rtl/cke_lowtime_timer.sv
module cke_lowtime_timer #(
    parameter int LIMIT = 40000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic done_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

    // R3: the count saturates at the limit and never wraps
    p_count_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

    // R3: once expired the timer stays expired
    p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> done_o);

endmodule

// File: rtl/cke_init_fsm.sv
module cke_init_fsm
    import cke_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic timer_done_i,
    input  logic release_i,
    output logic run_o
);

    init_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= INIT_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INIT_COUNT: begin
                if (timer_done_i) begin
                    state_d = release_i ? INIT_RUN : INIT_SW_WAIT;
                end
            end
            INIT_SW_WAIT: begin
                if (release_i) begin
                    state_d = INIT_RUN;
                end
            end
            INIT_RUN: state_d = INIT_RUN;
            default:  state_d = INIT_COUNT;
        endcase
    end

    assign run_o = (state_q == INIT_RUN);

    // R3: run can only be entered after the minimum low time
    p_no_early_run_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == INIT_RUN) |-> timer_done_i);

    // R10: run is final until reset
    p_run_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == INIT_RUN) |=> (state_q == INIT_RUN));

endmodule

// File: rtl/cke_rank_lane.sv
module cke_rank_lane
    import cke_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic fitted_i,
    input  logic req_i,
    output logic cke_o,
    output logic oe_o
);

    lane_state_e state_q, state_d;
    logic        cke_q;
    logic        oe_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= LANE_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_HOLD: begin
                if (!fitted_i) begin
                    state_d = LANE_OFF;
                end else if (run_i) begin
                    state_d = LANE_FOLLOW;
                end
            end
            LANE_FOLLOW: begin
                if (!fitted_i) begin
                    state_d = cke_q ? LANE_PARK : LANE_OFF;
                end
            end
            LANE_PARK: state_d = LANE_OFF;
            LANE_OFF: begin
                if (fitted_i) begin
                    state_d = run_i ? LANE_FOLLOW : LANE_HOLD;
                end
            end
            default: state_d = LANE_HOLD;
        endcase
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cke_q <= 1'b0;
            oe_q  <= 1'b1;
        end else begin
            cke_q <= (state_d == LANE_FOLLOW) && req_i;
            oe_q  <= (state_d != LANE_OFF);
        end
    end

    assign cke_o = cke_q;
    assign oe_o  = oe_q;

    // R2: CKE stays low while the init machine has not reached run
    p_hold_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |-> !cke_q);

    // R7: a floated rank never carries a high CKE value
    p_off_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_q |-> !cke_q);

    // R8: the enable only drops after a cycle with CKE low
    p_park_first_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(oe_q) |-> !$past(cke_q));

endmodule

// File: rtl/cke_rank_ctrl.sv
module cke_rank_ctrl #(
    parameter int RANKS      = 4,
    parameter int CLK_MHZ    = 200,
    parameter int MIN_LOW_US = 200
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_release_i,
    input  logic [RANKS-1:0] cfg_mask_i,
    input  logic [RANKS-1:0] cke_req_i,
    output logic [RANKS-1:0] cke_o,
    output logic [RANKS-1:0] cke_oe_o,
    output logic [RANKS-1:0] cs_oe_o,
    output logic             ready_o
);

    localparam int LIMIT = CLK_MHZ * MIN_LOW_US;

    logic             release_w;
    logic [RANKS-1:0] mask_w;
    logic             timer_done_w;
    logic             run_w;
    logic [RANKS-1:0] oe_w;

    cke_cfg_reg #(.RANKS(RANKS)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (cfg_wr_i),
        .release_i (cfg_release_i),
        .mask_i    (cfg_mask_i),
        .release_o (release_w),
        .mask_o    (mask_w)
    );

    cke_lowtime_timer #(.LIMIT(LIMIT)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .done_o (timer_done_w)
    );

    cke_init_fsm u_init (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .timer_done_i (timer_done_w),
        .release_i    (release_w),
        .run_o        (run_w)
    );

    for (genvar g = 0; g < RANKS; g++) begin : g_lane
        cke_rank_lane u_lane (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .run_i    (run_w),
            .fitted_i (mask_w[g]),
            .req_i    (cke_req_i[g]),
            .cke_o    (cke_o[g]),
            .oe_o     (oe_w[g])
        );
    end

    assign cke_oe_o = oe_w;
    assign cs_oe_o  = oe_w;
    assign ready_o  = run_w;

    // R1: reset puts every pin in its safe state
    p_reset_safe_r1: assert property (@(posedge clk_i)
        rst_i |=> (cke_o == '0 && cke_oe_o == '1 && !ready_o));

    // R10: ready never falls outside reset
    p_ready_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> ready_o);

endmodule

// File: tb/test_cke_rank_ctrl.sv
module test_cke_rank_ctrl;

    localparam int CLK_MHZ = 200;
    localparam int LOW_US  = 2;
    localparam int LIMIT   = CLK_MHZ * LOW_US;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic       cfg_rel;
    logic [3:0] cfg_mask;
    logic [3:0] req;
    logic [3:0] cke;
    logic [3:0] cke_oe;
    logic [3:0] cs_oe;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cke_rank_ctrl #(.RANKS(4), .CLK_MHZ(CLK_MHZ), .MIN_LOW_US(LOW_US)) i_cke_rank_ctrl (
        .clk_i         (clk),
        .rst_i         (rst),
        .cfg_wr_i      (cfg_wr),
        .cfg_release_i (cfg_rel),
        .cfg_mask_i    (cfg_mask),
        .cke_req_i     (req),
        .cke_o         (cke),
        .cke_oe_o      (cke_oe),
        .cs_oe_o       (cs_oe),
        .ready_o       (ready)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog R1: actual hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        cfg_wr = 1'b0;
    endtask

    task automatic check_all(input string tag, input logic [3:0] ecke,
                             input logic [3:0] eoe, input logic erdy);
        check({tag, " cke"}, {4'b0, cke}, {4'b0, ecke});
        check({tag, " cke_oe"}, {4'b0, cke_oe}, {4'b0, eoe});
        check({tag, " cs_oe"}, {4'b0, cs_oe}, {4'b0, eoe});
        check({tag, " ready"}, {7'b0, ready}, {7'b0, erdy});
    endtask

    // {wr, rel, mask[3:0], req[3:0], exp_cke[3:0], exp_oe[3:0], exp_ready}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 1'b1}, // R5 all high
        {1'b0, 1'b1, 4'b1111, 4'b1010, 4'b1010, 4'b1111, 1'b1}, // R5 pattern
        {1'b1, 1'b1, 4'b1110, 4'b1010, 4'b1010, 4'b1111, 1'b1}, // R6 write edge
        {1'b0, 1'b1, 4'b1110, 4'b1010, 4'b1010, 4'b1110, 1'b1}, // R7/R9 low rank floats now
        {1'b1, 1'b1, 4'b1100, 4'b1010, 4'b1010, 4'b1110, 1'b1}, // R6 remove high rank
        {1'b0, 1'b1, 4'b1100, 4'b1010, 4'b1000, 4'b1110, 1'b1}, // R8 park cycle
        {1'b0, 1'b1, 4'b1100, 4'b1010, 4'b1000, 4'b1100, 1'b1}, // R8 float
        {1'b1, 1'b0, 4'b1111, 4'b0111, 4'b0100, 4'b1100, 1'b1}, // R10 release cleared
        {1'b0, 1'b0, 4'b1111, 4'b0111, 4'b0111, 4'b1111, 1'b1}, // R9 re-fit follows
        {1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b1}  // R5/R10 all low
    };

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_rel = 1'b0; cfg_mask = 4'b0000; req = 4'b1111;

        // R1 during reset
        step(3);
        check_all("R1 in reset", 4'b0000, 4'b1111, 1'b0);

        // R3: release written on the first edge after reset
        rst = 1'b0; cfg_wr = 1'b1; cfg_rel = 1'b1; cfg_mask = 4'b1111;
        step(1);
        check_all("R1 after reset", 4'b0000, 4'b1111, 1'b0);
        step(LIMIT - 1);
        check_all("R2 R3 at limit", 4'b0000, 4'b1111, 1'b0);
        step(1);
        check_all("R3 ready edge", 4'b0000, 4'b1111, 1'b1);
        step(1);
        check_all("R3 follow edge", 4'b1111, 4'b1111, 1'b1);

        // vector table in run
        req = 4'b0000;
        step(1);
        for (int i = 0; i < NV; i++) begin
            cfg_wr   = VEC[i][18];
            cfg_rel  = VEC[i][17];
            cfg_mask = VEC[i][16:13];
            req      = VEC[i][12:9];
            step(1);
            check_all($sformatf("R5-table vec %0d", i), VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
        end

        // R2 R4 R7 R9: no release until well past the limit
        rst = 1'b1; req = 4'b1111;
        step(2);
        rst = 1'b0;
        step(20);
        cfg_wr = 1'b1; cfg_rel = 1'b0; cfg_mask = 4'b0111;
        step(1);
        check_all("R7 pre-run write edge", 4'b0000, 4'b1111, 1'b0);
        step(1);
        check_all("R7 pre-run float", 4'b0000, 4'b0111, 1'b0);
        cfg_wr = 1'b1; cfg_rel = 1'b0; cfg_mask = 4'b1111;
        step(2);
        check_all("R9 pre-run re-fit stays low", 4'b0000, 4'b1111, 1'b0);
        cfg_wr = 1'b1; cfg_rel = 1'b0; cfg_mask = 4'b0111;
        step(2);
        step(LIMIT + 10);
        check_all("R2 past limit no release", 4'b0000, 4'b0111, 1'b0);
        cfg_wr = 1'b1; cfg_rel = 1'b1; cfg_mask = 4'b0111;
        step(1);
        check_all("R4 release write edge", 4'b0000, 4'b0111, 1'b0);
        step(1);
        check_all("R4 ready", 4'b0000, 4'b0111, 1'b1);
        step(1);
        check_all("R4 follow", 4'b0111, 4'b0111, 1'b1);

        // R1 reset while running
        rst = 1'b1;
        step(1);
        check_all("R1 reset from run", 4'b0000, 4'b1111, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule